// File: doc/BRIEF.md
# Ethernet Transmit Buffer Controller

This block is the host-facing transmit side of a small Ethernet MAC. It holds two frame buffers that a processor fills through a 32-bit, word-only register bus. Each buffer has its own small register set: a frame length, a global interrupt gate and a command word. A command word either streams the buffer out as bytes (one per cycle, with valid and last markers) towards the line-side logic, or loads the 48-bit station address from the first six bytes of the buffer.

A command is queued in its own buffer's busy bits. A single engine serves one queued command at a time, with buffer 0 ahead of buffer 1 when both wait. When a command finishes, its busy bits drop and the block emits a one-cycle interrupt pulse, but only when both that buffer's interrupt enable and the top bit of buffer 0's gate register are set. Buffer 1's gate register is kept for software and has no effect.

Top module: `eth_tx_bufctl`

## Requirements
- R1: Bus address bit 12 low and word offset (bits 10:2) below the buffer word count selects buffer RAM; bit 11 picks buffer 0 or 1. A written word reads back unchanged, one cycle after the read request. Byte n of a buffer is bits 8*(n%4)+7:8*(n%4) of word n/4.
- R2: Each buffer's registers sit at word offsets 0x1FD (length), 0x1FE (gate) and 0x1FF (command) within its half, so at byte addresses 0x7F4/0x7F8/0x7FC for buffer 0 and 0xFF4/0xFF8/0xFFC for buffer 1. Length and gate read back all 32 written bits.
- R3: The command word uses bit 0 = start (busy), bit 1 = address-load select, bit 3 = interrupt enable. A read returns start and select as 1 while the command waits or runs and 0 after it finishes. The interrupt enable keeps its written value. All other bits read 0.
- R4: A command with bit 0 set and bit 1 clear sends the low 11 bits of the length register as that many bytes of the buffer, in byte order. tx_valid stays high on consecutive cycles for the whole frame.
- R5: tx_last is high only with the final byte. A length of 0 sends no byte, but the command still completes and its busy bit clears.
- R6: A command with bits 0 and 1 both set loads mac_addr with buffer bytes 0..5, byte 0 in bits 47:40, and sends no byte.
- R7: On completion, irq pulses for exactly one cycle if and only if the finishing buffer's interrupt-enable bit is set and bit 31 of buffer 0's gate register is set. For a frame, the pulse falls in the cycle of the last byte.
- R8: A command write to a buffer whose start bit reads 1 is ignored entirely, including its interrupt-enable bit.
- R9: A command issued to one buffer while the other buffer's frame is streaming is held and is sent in full after that frame ends, without mixing bytes.
- R10: After reset, all registers read 0, mac_addr is 0, and tx_valid, tx_last and irq are low.
- R11: Addresses with bit 12 set, or in the gap between the buffer RAM and the registers, read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | tx_data holds a frame byte |
| tx_last | output | 1 | Final byte of the frame |
| mac_addr | output | 48 | Station address |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A stuck or lost busy bit shows up on the first command readback after a write: the start bit stays 1 forever, or the queued frame never reaches the stream. A wrong byte index or buffer select changes the first stream byte, three cycles after the command write, and the scoreboard catches it on that byte. Broken interrupt gating shows as a missing or extra pulse in the cycle of the last byte. A command that should have been ignored but was accepted shows at once, in a changed interrupt-enable readback.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  localparam int unsigned NPORT = 2;
  localparam int unsigned WIDX_W = 9;
  localparam logic [8:0] REG_WORD0 = 9'h1FD;
  localparam int unsigned CMD_START = 0;
  localparam int unsigned CMD_LOAD  = 1;
  localparam int unsigned CMD_IEN   = 3;
  localparam int unsigned GATE_BIT  = 31;

  typedef enum logic [2:0] {RG_NONE, RG_RAM, RG_LEN, RG_GATE, RG_CMD} region_e;

  function automatic region_e decode_region(input logic [12:0] a, input int unsigned words);
    logic [8:0] w;
    w = a[10:2];
    if (a[12]) return RG_NONE;
    if (32'(w) < words) return RG_RAM;
    if (w == REG_WORD0) return RG_LEN;
    if (w == REG_WORD0 + 9'd1) return RG_GATE;
    if (w == REG_WORD0 + 9'd2) return RG_CMD;
    return RG_NONE;
  endfunction

  function automatic logic [7:0] byte_of(input logic [31:0] word, input logic [1:0] lane);
    return word[8*lane +: 8];
  endfunction

  function automatic logic [31:0] cmd_view(input logic s, input logic p, input logic i);
    return {28'd0, i, 1'b0, p, s};
  endfunction

endpackage

// File: rtl/eth_tx_bufram.sv
module eth_tx_bufram #(
  parameter int unsigned NBUF   = 2,
  parameter int unsigned WORDS  = 505,
  parameter int unsigned WIDX_W = 9,
  parameter int unsigned BSEL_W = 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BSEL_W-1:0] wbuf,
  input  logic [WIDX_W-1:0] widx,
  input  logic [31:0]       wdata,
  input  logic [BSEL_W-1:0] cbuf,
  input  logic [WIDX_W-1:0] cidx,
  output logic [31:0]       cword,
  input  logic [BSEL_W-1:0] ebuf,
  input  logic [WIDX_W-1:0] eidx,
  output logic [31:0]       eword
);
  localparam int unsigned DEPTH = NBUF * WORDS;
  localparam int unsigned AW = $clog2(DEPTH);

  logic [31:0] mem [DEPTH];

  function automatic logic in_range(input logic [BSEL_W-1:0] b, input logic [WIDX_W-1:0] i);
    return (32'(i) < WORDS) && (32'(b) < NBUF);
  endfunction

  function automatic logic [AW-1:0] flat(input logic [BSEL_W-1:0] b, input logic [WIDX_W-1:0] i);
    return AW'(32'(b) * WORDS + 32'(i));
  endfunction

  always_ff @(posedge clk) begin
    if (we && in_range(wbuf, widx)) mem[flat(wbuf, widx)] <= wdata;
  end

  always_comb begin
    cword = in_range(cbuf, cidx) ? mem[flat(cbuf, cidx)] : 32'd0;
    eword = in_range(ebuf, eidx) ? mem[flat(ebuf, eidx)] : 32'd0;
  end
endmodule

// File: rtl/eth_tx_portregs.sv
module eth_tx_portregs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_len,
  input  logic        wr_gate,
  input  logic        wr_cmd,
  input  logic [31:0] wdata,
  input  logic        done,
  output logic [31:0] len_q,
  output logic [31:0] gate_q,
  output logic        start_q,
  output logic        load_q,
  output logic        ien_q
);
  import eth_tx_pkg::*;

  logic cmd_taken;
  assign cmd_taken = wr_cmd && !start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0; gate_q <= '0;
      start_q <= 1'b0; load_q <= 1'b0; ien_q <= 1'b0;
    end else begin
      if (wr_len)  len_q  <= wdata;
      if (wr_gate) gate_q <= wdata;
      if (cmd_taken) begin
        ien_q   <= wdata[CMD_IEN];
        start_q <= wdata[CMD_START];
        load_q  <= wdata[CMD_START] & wdata[CMD_LOAD];
      end else if (done) begin
        start_q <= 1'b0;
        load_q  <= 1'b0;
      end
    end
  end

  p_busy_until_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !done) |=> start_q);
  p_ignored_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && start_q) |=> $stable(ien_q));
  p_done_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> start_q);
endmodule

// File: rtl/eth_tx_engine.sv
module eth_tx_engine #(
  parameter int unsigned NP     = 2,
  parameter int unsigned LEN_W  = 11,
  parameter int unsigned WIDX_W = 9,
  parameter int unsigned PW     = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NP-1:0]             req,
  input  logic [NP-1:0]             load,
  input  logic [NP-1:0][LEN_W-1:0]  len_in,
  input  logic [NP-1:0]             ien,
  input  logic                      gate_on,
  output logic [PW-1:0]             rd_port,
  output logic [WIDX_W-1:0]         rd_widx,
  input  logic [31:0]               rd_word,
  output logic [NP-1:0]             done,
  output logic [7:0]                tx_data,
  output logic                      tx_valid,
  output logic                      tx_last,
  output logic [47:0]               mac_addr,
  output logic                      irq
);
  import eth_tx_pkg::*;

  logic             run_q, mac_q;
  logic [PW-1:0]    port_q, grant;
  logic [LEN_W-1:0] idx_q, len_q;
  logic             have_req, cur_last, emit, step_done;
  logic [7:0]       cur_byte;

  always_comb begin
    grant = '0;
    for (int i = NP - 1; i >= 0; i--) if (req[i]) grant = PW'(i);
  end

  assign have_req  = |req;
  assign cur_last  = (len_q == '0) || (idx_q == len_q - 1'b1);
  assign emit      = run_q && (len_q != '0);
  assign step_done = run_q && cur_last;
  assign rd_port   = port_q;
  assign rd_widx   = WIDX_W'(idx_q >> 2);
  assign cur_byte  = byte_of(rd_word, idx_q[1:0]);

  for (genvar g = 0; g < NP; g++) begin : g_done
    assign done[g] = step_done && (port_q == PW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; mac_q <= 1'b0; port_q <= '0; idx_q <= '0; len_q <= '0;
      tx_data <= '0; tx_valid <= 1'b0; tx_last <= 1'b0; mac_addr <= '0; irq <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      irq      <= 1'b0;
      if (!run_q) begin
        if (have_req) begin
          run_q  <= 1'b1;
          port_q <= grant;
          mac_q  <= load[grant];
          len_q  <= load[grant] ? LEN_W'(6) : len_in[grant];
          idx_q  <= '0;
        end
      end else begin
        if (emit) begin
          if (mac_q) mac_addr <= {mac_addr[39:0], cur_byte};
          else begin
            tx_valid <= 1'b1;
            tx_data  <= cur_byte;
            tx_last  <= cur_last;
          end
        end
        if (cur_last) begin
          run_q <= 1'b0;
          irq   <= ien[port_q] && gate_on;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  p_last_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  p_irq_needs_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gate_on));
  p_single_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));
  p_valid_from_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(run_q && !mac_q));
endmodule

// File: rtl/eth_tx_bufctl.sv
module eth_tx_bufctl #(
  parameter int unsigned BUF_BYTES = 2020
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [12:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  output logic [47:0] mac_addr,
  output logic        irq
);
  import eth_tx_pkg::*;

  localparam int unsigned WORDS = (BUF_BYTES + 3) / 4;
  localparam int unsigned LEN_W = $clog2(BUF_BYTES + 1);
  localparam int unsigned PW    = $clog2(NPORT);

  region_e rg;
  logic [PW-1:0] sel;
  logic wr_any, rd_any;
  assign rg     = decode_region(bus_addr, WORDS);
  assign sel    = PW'(bus_addr[11]);
  assign wr_any = bus_valid && bus_write;
  assign rd_any = bus_valid && !bus_write;

  logic [NPORT-1:0][31:0]      len_r, gate_r;
  logic [NPORT-1:0][LEN_W-1:0] len_cut;
  logic [NPORT-1:0]            start_r, load_r, ien_r, done;
  logic [PW-1:0]               e_port;
  logic [WIDX_W-1:0]           e_widx;
  logic [31:0]                 e_word, c_word;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic hit;
    assign hit = wr_any && (sel == PW'(p));
    eth_tx_portregs u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_len(hit && rg == RG_LEN), .wr_gate(hit && rg == RG_GATE), .wr_cmd(hit && rg == RG_CMD),
      .wdata(bus_wdata), .done(done[p]),
      .len_q(len_r[p]), .gate_q(gate_r[p]),
      .start_q(start_r[p]), .load_q(load_r[p]), .ien_q(ien_r[p])
    );
    assign len_cut[p] = len_r[p][LEN_W-1:0];
  end

  eth_tx_bufram #(.NBUF(NPORT), .WORDS(WORDS), .WIDX_W(WIDX_W), .BSEL_W(PW)) u_ram (
    .clk(clk),
    .we(wr_any && rg == RG_RAM), .wbuf(sel), .widx(bus_addr[10:2]), .wdata(bus_wdata),
    .cbuf(sel), .cidx(bus_addr[10:2]), .cword(c_word),
    .ebuf(e_port), .eidx(e_widx), .eword(e_word)
  );

  eth_tx_engine #(.NP(NPORT), .LEN_W(LEN_W), .WIDX_W(WIDX_W), .PW(PW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .req(start_r), .load(load_r), .len_in(len_cut), .ien(ien_r),
    .gate_on(gate_r[0][GATE_BIT]),
    .rd_port(e_port), .rd_widx(e_widx), .rd_word(e_word), .done(done),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
    .mac_addr(mac_addr), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_any) begin
      case (rg)
        RG_RAM:  bus_rdata <= c_word;
        RG_LEN:  bus_rdata <= len_r[sel];
        RG_GATE: bus_rdata <= gate_r[sel];
        RG_CMD:  bus_rdata <= cmd_view(start_r[sel], load_r[sel], ien_r[sel]);
        default: bus_rdata <= '0;
      endcase
    end
  end

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: tb/eth_tx_bufctl_bench.sv
`timescale 1ns/1ps
module eth_tx_bufctl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, irq;
  logic [47:0] mac_addr;

  int checks = 0, fails = 0, irq_seen = 0, irq_exp = 0;
  logic [8:0] exp_q[$];
  logic prev_open = 1'b0;

  always #2 clk = ~clk;

  eth_tx_bufctl u_eth_tx_bufctl (.*);

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed + i * 7);
  endfunction
  function automatic logic [12:0] ram_a(input int p, input int w);
    return {1'b0, 1'(p), 9'(w), 2'b00};
  endfunction
  function automatic logic [12:0] reg_a(input int p, input int k);
    return {1'b0, 1'(p), 9'(9'h1FD + 9'(k)), 2'b00};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk); bus_valid = 1'b0; d = bus_rdata;
  endtask

  task automatic fill(input int p, input int seed, input int n);
    for (int w = 0; w < (n + 3) / 4; w++)
      wr(ram_a(p, w), {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)});
  endtask

  task automatic expect_frame(input int seed, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back({(i == n - 1), pat(seed, i)});
  endtask

  task automatic wait_idle(input int p);
    logic [31:0] d;
    for (int k = 0; k < 5000; k++) begin
      rd(reg_a(p, 2), d);
      if (!d[0]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_seen++;
      if (irq && tx_valid && !tx_last) begin
        checks++; fails++; $display("FAIL R7 irq mid-frame got=1 exp=0");
      end
      if (prev_open && !tx_valid) begin
        checks++; fails++; $display("FAIL R4 gap in frame got=0 exp=1");
      end
      if (tx_valid) begin
        if (exp_q.size() == 0) begin
          checks++; fails++; $display("FAIL R4 unexpected byte got=%h exp=none", tx_data);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check("R4/R5 stream byte", {55'd0, tx_last, tx_data}, {55'd0, e});
        end
      end
      prev_open = tx_valid && !tx_last;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 outputs", {tx_valid, tx_last, irq}, 3'b000);
    check("R10 mac", mac_addr, 48'd0);
    rd(reg_a(0, 2), d); check("R10 cmd0", d, 0);
    rd(reg_a(1, 0), d); check("R10 len1", d, 0);

    // R1 buffer RAM
    wr(ram_a(0, 0), 32'hA5A5_0001); wr(ram_a(1, 3), 32'h1234_5678); wr(ram_a(1, 504), 32'hCAFE_F00D);
    rd(ram_a(0, 0), d); check("R1 buf0 w0", d, 32'hA5A5_0001);
    rd(ram_a(1, 3), d); check("R1 buf1 w3", d, 32'h1234_5678);
    rd(ram_a(1, 504), d); check("R1 buf1 last word", d, 32'hCAFE_F00D);

    // R2 registers
    wr(reg_a(1, 0), 32'hDEAD_0005); wr(reg_a(1, 1), 32'h7FFF_FFFF);
    rd(reg_a(1, 0), d); check("R2 len1", d, 32'hDEAD_0005);
    rd(reg_a(1, 1), d); check("R2 gate1", d, 32'h7FFF_FFFF);

    // R11 unmapped
    wr(13'h1000, 32'hFFFF_FFFF); wr(13'h07E8, 32'hFFFF_FFFF);
    rd(13'h1000, d); check("R11 high region", d, 0);
    rd(13'h07E8, d); check("R11 gap", d, 0);
    rd(ram_a(0, 0), d); check("R11 ram untouched", d, 32'hA5A5_0001);

    // R4 frame of 9 bytes from buffer 0
    fill(0, 3, 9); wr(reg_a(0, 0), 9); expect_frame(3, 9);
    wr(reg_a(0, 2), 32'h1); wait_idle(0);
    check("R4 frame drained", exp_q.size(), 0);

    // R5 length 1 on buffer 1, length 0 on buffer 0
    fill(1, 40, 1); wr(reg_a(1, 0), 32'hF000_0001); expect_frame(40, 1);
    wr(reg_a(1, 2), 32'h1); wait_idle(1);
    check("R5 single byte", exp_q.size(), 0);
    wr(reg_a(0, 0), 0); wr(reg_a(0, 2), 32'h1); wait_idle(0);
    rd(reg_a(0, 2), d); check("R5 zero length completes", d, 0);
    check("R5 zero length no byte", exp_q.size(), 0);

    // R3 readback while busy, stray bits read 0
    fill(0, 11, 30); wr(reg_a(0, 0), 30); expect_frame(11, 30);
    wr(reg_a(0, 2), 32'hFFFF_FFF9);
    rd(reg_a(0, 2), d); check("R3 busy view", d, 32'h9);
    wait_idle(0);
    rd(reg_a(0, 2), d); check("R3 idle view", d, 32'h8);
    check("R7 no irq without gate", irq_seen, irq_exp);

    // R7 interrupt gating
    wr(reg_a(0, 1), 32'h8000_0000);
    fill(0, 60, 4); wr(reg_a(0, 0), 4); expect_frame(60, 4);
    wr(reg_a(0, 2), 32'h9); irq_exp++; wait_idle(0);
    check("R7 irq with gate and enable", irq_seen, irq_exp);
    wr(reg_a(0, 0), 0); wr(reg_a(0, 2), 32'h9); irq_exp++; wait_idle(0);
    check("R7 irq on zero length", irq_seen, irq_exp);
    fill(1, 70, 3); wr(reg_a(1, 0), 3); expect_frame(70, 3);
    wr(reg_a(1, 2), 32'h9); irq_exp++; wait_idle(1);
    check("R7 buffer1 gated by buffer0 gate", irq_seen, irq_exp);
    wr(reg_a(0, 1), 0); wr(reg_a(1, 1), 32'h8000_0000);
    expect_frame(70, 3); wr(reg_a(1, 2), 32'h9); wait_idle(1);
    check("R7 buffer1 gate ignored", irq_seen, irq_exp);
    wr(reg_a(0, 1), 32'h8000_0000);

    // R8 command while busy is ignored
    fill(0, 5, 30); wr(reg_a(0, 0), 30); expect_frame(5, 30);
    wr(reg_a(0, 2), 32'h1); wr(reg_a(0, 2), 32'hB);
    rd(reg_a(0, 2), d); check("R8 busy write ignored", d, 32'h1);
    wait_idle(0);
    rd(reg_a(0, 2), d); check("R8 enable unchanged", d, 0);
    check("R8 no irq from ignored write", irq_seen, irq_exp);
    check("R8 frame count", exp_q.size(), 0);

    // R6 station address load
    wr(ram_a(1, 0), 32'h3322_1100); wr(ram_a(1, 1), 32'h9999_5544);
    wr(reg_a(1, 2), 32'hB); irq_exp++; wait_idle(1);
    check("R6 mac loaded", mac_addr, 48'h0011_2233_4455);
    check("R6 no stream", exp_q.size(), 0);
    check("R7 irq on address load", irq_seen, irq_exp);

    // R9 command queued behind the other buffer's frame
    fill(0, 90, 20); fill(1, 120, 7);
    wr(reg_a(0, 0), 20); wr(reg_a(1, 0), 7);
    expect_frame(90, 20); expect_frame(120, 7);
    wr(reg_a(0, 2), 32'h1); wr(reg_a(1, 2), 32'h1);
    wait_idle(0); wait_idle(1);
    check("R9 both frames in order", exp_q.size(), 0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule